// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block sits on the device side of a parallel programming port for an on-chip program flash. An external programmer presents an address, a data byte and a three-bit operation code, then strobes an active-low program pulse. The block then runs a self-timed byte write, a lock-bit write or a whole-array erase. While an operation runs it reports busy on a ready output, and it answers polling reads of the byte in flight. It also returns fixed identification bytes and enforces read protection from the lock bits.

The flash array is a behavioural byte array inside the block, sized by an address-width parameter. The write and erase durations are counted in clock cycles and set by parameters, so a simulation can use short values. The programming-voltage variant is a single input that only changes one identification byte. Reset models a fresh device: the array is erased and no lock bit is set.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset every array byte reads FFh, `lock` is 000 and `ready` is 1.
- R2: With `mode`=001, a falling edge on `prog_n` starts a byte write. When it completes, the byte at the latched address holds the old contents ANDed with `din`. That byte is read back with `mode`=010.
- R3: While a byte write is in progress, a read (`mode`=010) of its address returns the value being stored with bit 7 inverted. Once the write is done the true value is returned.
- R4: `ready` falls on the clock edge that samples the `prog_n` falling edge of an accepted operation. It stays low for WR_CYC cycles for byte and lock writes and for ER_CYC cycles for an erase, then returns high.
- R5: While `ready` is low, further `prog_n` falling edges and changes of `mode`, `addr` or `din` do not alter the operation in progress and start no new one.
- R6: With `mode`=101, `dout` is 1Eh at address 30h and 52h at address 31h. At 32h it is FFh when `hv_variant`=1 and 05h when `hv_variant`=0. At any other address it is 00h.
- R7: With `mode`=011, a program pulse ORs `din[2:0]` into `lock` when the operation completes. A lock bit never returns to 0 except through an erase.
- R8: While `lock[0]` or `lock[1]` is set, a code read (`mode`=010) returns 00h. `lock[2]` alone does not block reads.
- R9: With `mode`=100, a program pulse erases the whole array. When the erase completes, every byte reads FFh and `lock` is 000.
- R10: Modes 000, 110 and 111 drive `dout` to 00h. A program pulse in any mode other than 001, 011 and 100 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (fresh-device state) |
| addr | input | ADDR_W | Byte address for writes, reads and identification |
| din | input | 8 | Write data; bits 2:0 select lock bits in lock mode |
| mode | input | 3 | Operation code |
| prog_n | input | 1 | Active-low program pulse, acted on at its falling edge |
| hv_variant | input | 1 | 1 selects the high-voltage variant identification byte |
| dout | output | 8 | Read, polling or identification data |
| ready | output | 1 | 1 when idle, 0 while an operation runs |
| lock | output | 3 | Current lock bits |

## Verification
The hardest states to reach from the ports are the ones where the bench alters the inputs in the middle of an operation. In those cases a second program pulse arrives, or the mode switches to erase, while a byte write is still counting down. The bench drives this on purpose and then reads back both the original target and the address given with the ignored pulse. Polling is also exercised mid-write: the bench switches to read mode at the pending address between the pulse and completion. A behavioural model that tracks pending operations compares `dout`, `ready` and `lock` on every clock.

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int ADDR_W = 8,
  parameter int WR_CYC = 24,
  parameter int ER_CYC = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [2:0]        mode,
  input  logic              prog_n,
  input  logic              hv_variant,
  output logic [7:0]        dout,
  output logic              ready,
  output logic [2:0]        lock
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (WR_CYC > ER_CYC) ? WR_CYC : ER_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [2:0] M_WR = 3'd1, M_RD = 3'd2, M_LK = 3'd3, M_ER = 3'd4, M_SG = 3'd5;

  logic [7:0]        mem [DEPTH];
  logic              busy, prog_q;
  logic [CW-1:0]     cnt;
  logic [2:0]        op_q, lock_q;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wval;

  wire prog_op = (mode == M_WR) || (mode == M_LK) || (mode == M_ER);
  wire start   = prog_q && !prog_n && prog_op && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      prog_q <= 1'b1;
      cnt    <= '0;
      op_q   <= 3'd0;
      waddr  <= '0;
      wval   <= 8'hFF;
      lock_q <= 3'b000;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      prog_q <= prog_n;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          case (op_q)
            M_WR: mem[waddr] <= wval;
            M_LK: lock_q <= lock_q | wval[2:0];
            M_ER: begin
              for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
              lock_q <= 3'b000;
            end
            default: ;
          endcase
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        op_q  <= mode;
        waddr <= addr;
        wval  <= (mode == M_WR) ? (mem[addr] & din) : din;
        cnt   <= (mode == M_ER) ? CW'(ER_CYC - 1) : CW'(WR_CYC - 1);
      end
    end
  end

  always_comb begin
    dout = 8'h00;
    case (mode)
      M_RD: if (!(lock_q[0] || lock_q[1])) begin
        if (busy && op_q == M_WR && addr == waddr) dout = {~wval[7], wval[6:0]};
        else dout = mem[addr];
      end
      M_SG: begin
        if (addr == ADDR_W'(48))      dout = 8'h1E;
        else if (addr == ADDR_W'(49)) dout = 8'h52;
        else if (addr == ADDR_W'(50)) dout = hv_variant ? 8'hFF : 8'h05;
      end
      default: dout = 8'h00;
    endcase
  end

  assign ready = ~busy;
  assign lock  = lock_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(prog_n) && ready && prog_op) |=> !ready); // R4
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && $stable(op_q) && $stable(waddr) && $stable(wval))); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock) & ~lock) != 3'b000) |-> ($past(busy) && $past(op_q) == M_ER)); // R7
  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RD && (lock[0] || lock[1])) |-> (dout == 8'h00)); // R8
  AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(op_q) == M_ER && !busy) |-> (lock == 3'b000)); // R9
endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
  localparam int AW = 8, WR = 24, ER = 60;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [2:0] mode = '0;
  logic prog_n = 1'b1, hv = 1'b1;
  logic [7:0] dout;
  logic ready;
  logic [2:0] lock;
  int checks = 0, fails = 0;

  flash_prog_ctrl #(.ADDR_W(AW), .WR_CYC(WR), .ER_CYC(ER)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode(mode),
    .prog_n(prog_n), .hv_variant(hv), .dout(dout), .ready(ready), .lock(lock));

  always #5 clk = ~clk;

  // behavioural reference
  logic [7:0] m_arr [256];
  logic [2:0] m_lock;
  int m_left, m_op, m_addr;
  logic [7:0] m_val;
  logic m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_arr[i] = 8'hFF;
      m_lock = 0; m_left = 0; m_op = 0; m_addr = 0; m_val = 8'hFF; m_prev = 1;
    end else begin
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          if (m_op == 1) m_arr[m_addr] = m_val;
          else if (m_op == 3) m_lock = m_lock | m_val[2:0];
          else if (m_op == 4) begin
            for (int i = 0; i < 256; i++) m_arr[i] = 8'hFF;
            m_lock = 0;
          end
        end
      end else if (m_prev && !prog_n && (mode == 1 || mode == 3 || mode == 4)) begin
        m_op = mode; m_addr = addr;
        m_val = (mode == 1) ? (m_arr[addr] & din) : din;
        m_left = (mode == 4) ? ER : WR;
      end
      m_prev = prog_n;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [7:0] e;
    string t;
    e = 8'h00; t = "R10";
    if (mode == 2) begin
      if (m_lock[0] || m_lock[1]) t = "R8";
      else if (m_left > 0 && m_op == 1 && addr == m_addr) begin
        t = "R3"; e = {~m_val[7], m_val[6:0]};
      end else begin t = "R2"; e = m_arr[addr]; end
    end else if (mode == 5) begin
      t = "R6";
      if (addr == 8'h30) e = 8'h1E;
      else if (addr == 8'h31) e = 8'h52;
      else if (addr == 8'h32) e = hv ? 8'hFF : 8'h05;
    end
    chk(t, dout, e);
    chk("R4", ready, m_left == 0);
    chk("R7", lock, m_lock);
  end

  task automatic set_in(input logic [2:0] m, input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2; mode = m; addr = a; din = d;
  endtask

  task automatic pulse(input logic [2:0] m, input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2; mode = m; addr = a; din = d; prog_n = 1'b0;
    @(posedge clk); #2; prog_n = 1'b1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    @(negedge clk);
    while (ready == 1'b0) begin n++; @(negedge clk); end
  endtask

  task automatic read_at(input logic [7:0] a, input logic [7:0] e, input string tag);
    set_in(3'd2, a, 8'h00);
    @(negedge clk);
    chk(tag, dout, e);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ready, 1); chk("R1", lock, 0);
    read_at(8'h10, 8'hFF, "R1");
    read_at(8'hFE, 8'hFF, "R1");

    // byte write with polling
    pulse(3'd1, 8'h10, 8'hA5);
    set_in(3'd2, 8'h10, 8'h00);
    @(negedge clk);
    chk("R4", ready, 0);
    chk("R3", dout, 8'h25);
    wait_idle(n);
    chk("R3", dout, 8'hA5);
    read_at(8'h10, 8'hA5, "R2");

    pulse(3'd1, 8'h10, 8'h3C);
    wait_idle(n);
    chk("R4", n, WR);
    read_at(8'h10, 8'h24, "R2");

    // pulses and mode changes during busy
    pulse(3'd1, 8'h20, 8'h11);
    pulse(3'd1, 8'h21, 8'h00);
    pulse(3'd4, 8'h00, 8'h00);
    set_in(3'd3, 8'h22, 8'h07);
    wait_idle(n);
    chk("R5", lock, 0);
    read_at(8'h21, 8'hFF, "R5");
    read_at(8'h20, 8'h11, "R5");
    read_at(8'h10, 8'h24, "R5");

    // identification
    set_in(3'd5, 8'h30, 0); @(negedge clk); chk("R6", dout, 8'h1E);
    set_in(3'd5, 8'h31, 0); @(negedge clk); chk("R6", dout, 8'h52);
    set_in(3'd5, 8'h32, 0); @(negedge clk); chk("R6", dout, 8'hFF);
    hv = 1'b0; @(negedge clk); chk("R6", dout, 8'h05);
    set_in(3'd5, 8'h33, 0); @(negedge clk); chk("R6", dout, 8'h00);

    // pulses in non-program modes
    pulse(3'd0, 8'h10, 8'h00);
    @(negedge clk); chk("R10", ready, 1); chk("R10", dout, 0);
    pulse(3'd6, 8'h10, 8'h00);
    @(negedge clk); chk("R10", ready, 1);
    pulse(3'd2, 8'h10, 8'h00);
    @(negedge clk); chk("R10", ready, 1);
    read_at(8'h10, 8'h24, "R10");

    // lock bits
    pulse(3'd3, 8'h00, 8'h04);
    wait_idle(n);
    chk("R7", lock, 3'b100);
    read_at(8'h10, 8'h24, "R8");
    pulse(3'd3, 8'h00, 8'h01);
    wait_idle(n);
    chk("R7", lock, 3'b101);
    read_at(8'h10, 8'h00, "R8");
    pulse(3'd3, 8'h00, 8'h00);
    wait_idle(n);
    chk("R7", lock, 3'b101);

    // erase
    pulse(3'd4, 8'h00, 8'h00);
    wait_idle(n);
    chk("R4", n, ER);
    chk("R9", lock, 0);
    read_at(8'h10, 8'hFF, "R9");
    read_at(8'h20, 8'hFF, "R9");
    pulse(3'd1, 8'h20, 8'h0F);
    wait_idle(n);
    read_at(8'h20, 8'h0F, "R2");

    repeat (3) @(posedge clk);
    report();
  end
endmodule